// File: doc/BRIEF.md
# Complementary PWM Pair with Deadtime

This block produces a top/bottom pair of complementary pulse-width-modulated outputs from a single programmable time base. The counter can run edge-aligned (saw-tooth) or center-aligned (up then down), and the top output is requested while the counter lies below the duty value. The bottom output is requested for the rest of the period. Each output's activating edge is held back by a programmable deadtime, so the two switches of a half bridge are never driven together, and each output has its own active level.

Software loads modulus, duty, deadtime, alignment and reload ratio through a small write port into a shadow set. The shadow set is copied into the working set only at a reload event, which happens at the end of every N-th PWM period. A one-clock strobe marks the first clock of each period that runs on freshly loaded values. The polarity bits act on the next clock.

Top module: `cpwm_pair`

## Requirements
- R1: After reset both pins sit at their inactive level (0 under the reset polarity, which is active-high for both), the reload strobe is low, the reset working set is modulus RST_MOD, duty 0, deadtime 0, edge alignment and N = 1, and the first reload strobe comes RST_MOD clocks after reset is released.
- R2: In edge alignment the counter runs 0 to M-1 and wraps, so a period lasts M clocks, and the top output is requested while the counter is below the duty D: min(D, M) clocks per period.
- R3: In center alignment the counter counts 0 up to M-1, holds one clock, counts down to 0 and holds one clock, so a period lasts 2M clocks, and the top output is requested for 2*min(D, M) clocks centred on the counter minimum.
- R4: D = 0 keeps the top output inactive and the bottom output active for the whole period; D >= M does the reverse.
- R5: A request that starts is turned into an active output only after the deadtime T clocks have passed (one register stage plus T clocks), a request of T clocks or fewer gives no pulse, release is not delayed, and the two outputs are never active in the same clock.
- R6: Each output pin equals its active flag when its polarity bit is 1 and the inverse when it is 0; a polarity write acts from the next clock, without waiting for a reload.
- R7: Write port select codes: 0 modulus (a written 0 is stored as 1), 1 duty, 2 deadtime (low DT_W bits), 3 alignment (bit 0: 1 = center), 4 reload ratio N-1 (low RLD_W bits), 5 polarity (bit 0 top, bit 1 bottom, 1 = active-high); other codes have no effect.
- R8: A reload happens at the end of every N-th period; reload_evt is high for exactly the first clock of the following period, while the counter is at its minimum.
- R9: Writes to modulus, duty, deadtime, alignment and ratio leave the outputs unchanged until the next reload, even when made in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the shadow/polarity registers |
| wr_sel | input | 3 | Register select code (see R7) |
| wr_data | input | CNT_W | Write data |
| top_out | output | 1 | Top output pin, after deadtime and polarity |
| bot_out | output | 1 | Bottom output pin, after deadtime and polarity |
| reload_evt | output | 1 | One-clock strobe in the first clock of a reloaded period |

## Verification
A wrong counter or period divider shows within one period as a pulse count per period that departs from the arithmetic value, or as a reload strobe that comes too early or too late, so the bench compares every pin on every clock against a position-based model and also counts active clocks per period across a sweep of alignment, modulus, duty and deadtime. A wrong deadtime counter shows in the very next pulse as a leading edge moved by whole clocks, or as a narrow pulse that leaks through, and an overlap of top and bottom is visible in the same clock. A shadow value leaking into the working set early shows as a changed pulse count inside the window between two reload strobes.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_MOD   = 3'd0,
      SEL_DUTY  = 3'd1,
      SEL_DEAD  = 3'd2,
      SEL_ALIGN = 3'd3,
      SEL_RATIO = 3'd4,
      SEL_POL   = 3'd5
   } sel_e;

endpackage

// File: rtl/cpwm_bank.sv
module cpwm_bank
   import cpwm_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int DT_W    = 4,
   parameter int RLD_W   = 3,
   parameter int RST_MOD = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             reload,
   output logic [CNT_W-1:0] mod_q,
   output logic [CNT_W-1:0] duty_q,
   output logic [DT_W-1:0]  dead_q,
   output logic             align_q,
   output logic [RLD_W-1:0] ratio_q,
   output logic             pol_top,
   output logic             pol_bot
);

   typedef struct packed {
      logic [CNT_W-1:0] modv;
      logic [CNT_W-1:0] duty;
      logic [DT_W-1:0]  dead;
      logic             align;
      logic [RLD_W-1:0] ratio;
   } set_t;

   localparam set_t RST_SET = '{modv: CNT_W'(RST_MOD), duty: '0, dead: '0,
                                align: 1'b0, ratio: '0};

   set_t             shadow;
   set_t             working;
   logic [CNT_W-1:0] mod_wr;

   // a zero modulus would give no period at all; store it as one clock
   assign mod_wr = (wr_data == '0) ? CNT_W'(1) : wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow  <= RST_SET;
         working <= RST_SET;
         pol_top <= 1'b1;
         pol_bot <= 1'b1;
      end else begin
         if (reload) working <= shadow;
         if (wr_en) begin
            case (sel_e'(wr_sel))
               SEL_MOD:   shadow.modv  <= mod_wr;
               SEL_DUTY:  shadow.duty  <= wr_data;
               SEL_DEAD:  shadow.dead  <= wr_data[DT_W-1:0];
               SEL_ALIGN: shadow.align <= wr_data[0];
               SEL_RATIO: shadow.ratio <= wr_data[RLD_W-1:0];
               SEL_POL: begin
                  pol_top <= wr_data[0];
                  pol_bot <= wr_data[1];
               end
               default: ;
            endcase
         end
      end
   end

   assign mod_q   = working.modv;
   assign duty_q  = working.duty;
   assign dead_q  = working.dead;
   assign align_q = working.align;
   assign ratio_q = working.ratio;

   // R9: the working set only moves on a reload
   assert_hold_until_reload_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> $stable(working));

   // R7: modulus used by the time base is never zero
   assert_mod_nonzero_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      working.modv != '0);

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
   parameter int CNT_W     = 8,
   parameter int RLD_W     = 3,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] mod,
   input  logic             align,
   input  logic [RLD_W-1:0] ratio,
   output logic [CNT_W-1:0] cnt,
   output logic             reload_now,
   output logic             reload_evt
);

   logic             dn;
   logic             is_ctr;
   logic             at_top;
   logic             end_cyc;
   logic [RLD_W-1:0] pcnt;

   if (CENTER_EN) begin : g_center
      assign is_ctr = align;
   end else begin : g_edge_only
      assign is_ctr = 1'b0;
   end

   assign at_top     = (cnt == mod - 1'b1);
   assign end_cyc    = is_ctr ? (dn && cnt == '0) : at_top;
   assign reload_now = end_cyc && (pcnt == ratio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         dn         <= 1'b0;
         pcnt       <= '0;
         reload_evt <= 1'b0;
      end else begin
         reload_evt <= reload_now;
         if (end_cyc) begin
            cnt  <= '0;
            dn   <= 1'b0;
            pcnt <= reload_now ? '0 : pcnt + 1'b1;
         end else if (!is_ctr) begin
            cnt <= cnt + 1'b1;
         end else if (!dn) begin
            if (at_top) dn  <= 1'b1;
            else        cnt <= cnt + 1'b1;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // R2: the counter stays inside the modulus in both alignments
   assert_cnt_below_mod_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt < mod);

   // R3: at the top of an up-count the value is held one clock and the direction flips
   assert_turn_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (is_ctr && !dn && at_top) |=> (dn && $stable(cnt)));

   // R8: the strobe marks the counter minimum at the start of a period
   assert_evt_at_min_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      reload_evt |-> (cnt == '0 && !dn));

   // R8: the period divider never passes the programmed ratio
   assert_ratio_bound_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= ratio);

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [DT_W-1:0] dead,
   output logic            act
);

   logic [DT_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= '0;
         act <= 1'b0;
      end else begin
         if (!req)            run <= '0;
         else if (run != '1) run <= run + 1'b1;
         act <= req && (run >= dead);
      end
   end

   // R5: with a nonzero deadtime a fresh request never shows on the next clock
   assert_lead_delay_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (dead != '0 && $rose(req)) |=> !act);

endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
   import cpwm_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int DT_W      = 4,
   parameter int RLD_W     = 3,
   parameter int RST_MOD   = 8,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             top_out,
   output logic             bot_out,
   output logic             reload_evt
);

   localparam int N_OUT = 2;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("cpwm_pair: CNT_W must be at least 2");
   end
   if (DT_W < 1 || DT_W > CNT_W) begin : g_bad_dt
      $error("cpwm_pair: DT_W must be 1..CNT_W");
   end
   if (RLD_W < 1 || RLD_W > CNT_W) begin : g_bad_rld
      $error("cpwm_pair: RLD_W must be 1..CNT_W");
   end
   if (RST_MOD < 1 || RST_MOD >= (1 << CNT_W)) begin : g_bad_rst
      $error("cpwm_pair: RST_MOD out of range");
   end

   logic [CNT_W-1:0] mod_q;
   logic [CNT_W-1:0] duty_q;
   logic [DT_W-1:0]  dead_q;
   logic             align_q;
   logic [RLD_W-1:0] ratio_q;
   logic             pol_top;
   logic             pol_bot;
   logic [CNT_W-1:0] cnt;
   logic             reload_now;
   logic             raw;
   logic [N_OUT-1:0] req;
   logic [N_OUT-1:0] act;
   logic [N_OUT-1:0] pol;
   logic [N_OUT-1:0] pin;

   cpwm_bank #(
      .CNT_W(CNT_W), .DT_W(DT_W), .RLD_W(RLD_W), .RST_MOD(RST_MOD)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .reload(reload_now),
      .mod_q(mod_q), .duty_q(duty_q), .dead_q(dead_q), .align_q(align_q),
      .ratio_q(ratio_q), .pol_top(pol_top), .pol_bot(pol_bot)
   );

   cpwm_timebase #(
      .CNT_W(CNT_W), .RLD_W(RLD_W), .CENTER_EN(CENTER_EN)
   ) u_tb (
      .clk(clk), .rst_n(rst_n), .mod(mod_q), .align(align_q), .ratio(ratio_q),
      .cnt(cnt), .reload_now(reload_now), .reload_evt(reload_evt)
   );

   assign raw = (cnt < duty_q);
   assign req = {~raw, raw};
   assign pol = {pol_bot, pol_top};

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      cpwm_deadband #(.DT_W(DT_W)) u_db (
         .clk(clk), .rst_n(rst_n), .req(req[i]), .dead(dead_q), .act(act[i])
      );
      assign pin[i] = pol[i] ? act[i] : ~act[i];
   end

   assign top_out = pin[0];
   assign bot_out = pin[1];

   // R5: the two switches are never on together
   assert_no_overlap_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(act[0] && act[1]));

endmodule

// File: tb/test_cpwm_pair.sv
`timescale 1ns/100ps
module test_cpwm_pair;

   localparam int CW = 8;
   localparam int DW = 4;
   localparam int RW = 3;
   localparam int RM = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [CW-1:0] wr_data = '0;
   logic          top_out, bot_out, reload_evt;

   cpwm_pair #(.CNT_W(CW), .DT_W(DW), .RLD_W(RW), .RST_MOD(RM)) i_cpwm_pair (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .top_out(top_out), .bot_out(bot_out), .reload_evt(reload_evt)
   );

   always #2.5 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model: working set, shadow set, position in period
   int m_mod, m_duty, m_dead, m_ctr, m_ratio;
   int s_mod, s_duty, s_dead, s_ctr, s_ratio;
   int pol_t, pol_b;
   int pos, pcount, run_t, run_b;
   int e_t, e_b, e_evt;
   int s_top, s_bot, s_evt;
   string cur_req = "R1";

   task automatic chk(string req, string what, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   function automatic int per_now();
      return (m_ctr != 0) ? 2 * m_mod : m_mod;
   endfunction

   function automatic int raw_at(int p);
      if (m_ctr == 0) return (p < m_duty) ? 1 : 0;
      return ((p < m_duty) || (p >= 2 * m_mod - m_duty)) ? 1 : 0;
   endfunction

   task automatic model_init();
      m_mod = RM; m_duty = 0; m_dead = 0; m_ctr = 0; m_ratio = 0;
      s_mod = RM; s_duty = 0; s_dead = 0; s_ctr = 0; s_ratio = 0;
      pol_t = 1; pol_b = 1;
      pos = 0; pcount = 0; run_t = 0; run_b = 0;
      e_t = 0; e_b = 0; e_evt = 0;
   endtask

   task automatic step(bit we, int a, int dat);
      int r, nt, nb, per;
      r   = raw_at(pos);
      nt  = (r == 1 && run_t >= m_dead) ? 1 : 0;
      nb  = (r == 0 && run_b >= m_dead) ? 1 : 0;
      run_t = (r == 1) ? run_t + 1 : 0;
      run_b = (r == 0) ? run_b + 1 : 0;
      per = per_now();
      e_evt = 0;
      if (pos == per - 1) begin
         pos = 0;
         if (pcount == m_ratio) begin
            m_mod = s_mod; m_duty = s_duty; m_dead = s_dead;
            m_ctr = s_ctr; m_ratio = s_ratio;
            pcount = 0;
            e_evt = 1;
         end else begin
            pcount++;
         end
      end else begin
         pos++;
      end
      if (we) begin
         case (a)
            0: s_mod   = ((dat % 256) == 0) ? 1 : dat % 256;
            1: s_duty  = dat % 256;
            2: s_dead  = dat % 16;
            3: s_ctr   = dat % 2;
            4: s_ratio = dat % 8;
            5: begin pol_t = dat % 2; pol_b = (dat / 2) % 2; end
            default: ;
         endcase
      end
      e_t = nt;
      e_b = nb;
   endtask

   task automatic tick(bit we, int a, int dat);
      @(negedge clk);
      s_top = int'(top_out);
      s_bot = int'(bot_out);
      s_evt = int'(reload_evt);
      chk(cur_req, "top pin", s_top, (pol_t != 0) ? e_t : 1 - e_t);
      chk(cur_req, "bottom pin", s_bot, (pol_b != 0) ? e_b : 1 - e_b);
      chk("R8", "reload strobe", s_evt, e_evt);
      if (pol_t != 0 && pol_b != 0) chk("R5", "overlap", s_top & s_bot, 0);
      wr_en   = we;
      wr_sel  = a[2:0];
      wr_data = dat[CW-1:0];
      step(we, a, dat);
   endtask

   task automatic wait_evt(output int n);
      n = 0;
      do begin
         tick(1'b0, 0, 0);
         n++;
      end while (s_evt == 0 && n < 4000);
   endtask

   initial begin
      int n, ct, cb, me, per, hi, lo, et, eb, dt;
      string tag;
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_init();
      // R1: reset levels seen at the first clock after release
      chk("R1", "top after reset", int'(top_out), 0);
      chk("R1", "bottom after reset", int'(bot_out), 0);
      chk("R1", "strobe after reset", int'(reload_evt), 0);
      step(1'b0, 0, 0);

      // R1: with N = 1 the first reload ends the first period of RST_MOD clocks
      cur_req = "R1";
      wait_evt(n);
      chk("R1", "clocks to first reload", n, RM);

      // R6: polarity acts on the next clock
      cur_req = "R6";
      tick(1'b1, 5, 0);
      tick(1'b0, 0, 0);
      chk("R6", "top idle level active-low", s_top, 1);
      chk("R6", "bottom active level active-low", s_bot, 0);
      tick(1'b1, 5, 3);
      tick(1'b0, 0, 0);
      chk("R6", "top idle level active-high", s_top, 0);
      chk("R6", "bottom active level active-high", s_bot, 1);
      tick(1'b1, 7, 0);  // R7: unused select code
      tick(1'b0, 0, 0);
      chk("R7", "unused code keeps bottom", s_bot, 1);

      // sweep alignment, modulus, duty and deadtime; count per period
      for (int ctr = 0; ctr < 2; ctr++) begin
         for (int m = 0; m <= 5; m++) begin
            me = (m == 0) ? 1 : m;
            for (int d = 0; d <= me + 1; d++) begin
               for (int k = 0; k < 3; k++) begin
                  dt = (k == 2) ? 3 : k;
                  cur_req = (ctr != 0) ? "R3" : "R2";
                  tick(1'b1, 0, m);
                  tick(1'b1, 1, d);
                  tick(1'b1, 2, dt);
                  tick(1'b1, 3, ctr);
                  wait_evt(n);
                  wait_evt(n);
                  per = (ctr != 0) ? 2 * me : me;
                  repeat (2 * per + 4) tick(1'b0, 0, 0);
                  ct = 0; cb = 0;
                  for (int c = 0; c < per; c++) begin
                     tick(1'b0, 0, 0);
                     ct += s_top;
                     cb += s_bot;
                  end
                  hi = ((d < me) ? d : me) * ((ctr != 0) ? 2 : 1);
                  lo = per - hi;
                  et = (hi == 0) ? 0 : (hi == per) ? per : ((hi > dt) ? hi - dt : 0);
                  eb = (lo == 0) ? 0 : (lo == per) ? per : ((lo > dt) ? lo - dt : 0);
                  if (m == 0)                    tag = "R7";
                  else if (dt != 0)              tag = "R5";
                  else if (d == 0 || d >= me)    tag = "R4";
                  else                           tag = cur_req;
                  chk(tag, $sformatf("top count ctr=%0d m=%0d d=%0d t=%0d", ctr, m, d, dt), ct, et);
                  chk(tag, $sformatf("bottom count ctr=%0d m=%0d d=%0d t=%0d", ctr, m, d, dt), cb, eb);
               end
            end
         end
      end

      // R8 and R9: reload every fourth period; a mid-period write waits for it
      cur_req = "R9";
      tick(1'b1, 0, 6);
      tick(1'b1, 1, 2);
      tick(1'b1, 2, 0);
      tick(1'b1, 3, 0);
      tick(1'b1, 4, 3);
      wait_evt(n);
      wait_evt(n);
      wait_evt(n);
      chk("R8", "clocks between reloads with N=4", n, 24);
      ct = s_top;
      for (int c = 1; c < 24; c++) begin
         if (c == 3) tick(1'b1, 1, 5);
         else        tick(1'b0, 0, 0);
         ct += s_top;
      end
      tick(1'b0, 0, 0);
      chk("R8", "strobe after four periods", s_evt, 1);
      chk("R9", "top clocks before reload", ct, 8);
      ct = s_top;
      for (int c = 1; c < 6; c++) begin
         tick(1'b0, 0, 0);
         ct += s_top;
      end
      chk("R9", "top clocks after reload", ct, 5);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule